// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Generator

This block turns the bus clock into the serial clock of an SPI master. A frame engine raises a run request to start a frame and drops it to end one. While the block is enabled and the request is high, the serial clock toggles at a rate set by a divider value and a mode bit. Next to the clock it gives two single-cycle pulses. One marks the edge where the clock leaves its idle level. The other marks the edge where it returns. The shifter uses them to decide when to sample and when to drive.

There are two division laws. In power-of-two mode the low four bits of the divider act as an exponent. In linear mode all eight bits set an even divide ratio. The divider value, the mode and the polarity are captured when a frame starts. Changes made during a frame therefore reach the wire only at the following frame. While no frame runs, the clock rests at the level given by the polarity input.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `clk_mode` = 0, the serial clock period is 2^(G+1) bus cycles, where G = `div_val[3:0]`, and each level lasts exactly half the period. The bits `div_val[7:4]` have no effect in this mode.
- R2: With `clk_mode` = 1, the serial clock period is 2*(G+1) bus cycles, where G = `div_val[7:0]`, and each level lasts exactly half the period.
- R3: The mode bit selects the division law: 0 selects power-of-two, 1 selects linear.
- R4: A frame starts at the first rising bus-clock edge where `en` and `run` are both high. The first serial-clock edge comes H cycles after that edge, where H is the half period, and further edges follow every H cycles. `lead_pulse` is high for exactly the cycle in which `sclk` leaves the idle level. `trail_pulse` is high for exactly the cycle in which `sclk` returns to the idle level. The two pulses alternate, starting with `lead_pulse`.
- R5: While `en` or `run` is low, `sclk` equals `cpol` from the next cycle on and neither pulse is raised. Dropping `run` in the middle of a frame returns `sclk` to idle without a `trail_pulse`, even when the drop lands on the cycle of a scheduled edge.
- R6: The idle level of `sclk` is low when `cpol` = 0 and high when `cpol` = 1. The polarity used for the pulses is captured at frame start.
- R7: Changes to `div_val` or `clk_mode` during a frame do not change the timing of that frame. They apply from the next frame.
- R8: The fastest setting (mode 0, G = 0) toggles `sclk` on every bus cycle, which is half the bus rate. No setting makes `sclk` faster than that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable |
| run | input | 1 | Frame start/stop request from the frame engine |
| clk_mode | input | 1 | Division law: 0 power-of-two, 1 linear |
| cpol | input | 1 | Clock polarity, which is the idle level |
| div_val | input | 8 | Divider value G |
| sclk | output | 1 | Serial clock |
| lead_pulse | output | 1 | One-cycle pulse on the edge that leaves idle |
| trail_pulse | output | 1 | One-cycle pulse on the edge that returns to idle |

## Verification
Two events can fall in the same cycle. One is a stop request, and the other is a half-period expiry that would toggle the clock. The bench drops `run` so that the stop lands on exactly the cycle where a trailing edge is due. It then requires that no `trail_pulse` appears and that `sclk` is already at idle in the next sample. Any pulse that the scoreboard did not predict counts as a mismatch. A second collision is a divider or mode change during a running frame. This is judged by comparing the edge times against values the bench computes from the settings captured at frame start.

// File: rtl/sclk_pkg.sv
package sclk_pkg;
  // Division law chosen by the mode bit
  typedef enum logic {
    DIV_POW2 = 1'b0,
    DIV_LIN  = 1'b1
  } div_mode_e;
endpackage

// File: rtl/sclk_half_calc.sv
// Converts (mode, G) into half-period minus one, in bus cycles.
module sclk_half_calc
  import sclk_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8,
  parameter int CNT_W = 15
) (
  input  div_mode_e          mode,
  input  logic [LIN_W-1:0]   div,
  output logic [CNT_W-1:0]   half_m1
);
  logic [CNT_W-1:0] pow_m1;
  logic [CNT_W-1:0] lin_m1;

  // power-of-two law: half period = 2^G, so half-1 = 2^G - 1 (wraps correctly at the top)
  assign pow_m1 = (CNT_W'(1) << div[EXP_W-1:0]) - CNT_W'(1);

  // linear law: half period = G+1, so half-1 = G
  generate
    if (CNT_W > LIN_W) begin : g_lin_pad
      assign lin_m1 = {{(CNT_W-LIN_W){1'b0}}, div};
    end else begin : g_lin_direct
      assign lin_m1 = div[CNT_W-1:0];
    end
  endgenerate

  assign half_m1 = (mode == DIV_LIN) ? lin_m1 : pow_m1;
endmodule

// File: rtl/sclk_frame_ctl.sv
// Tracks frame activity and captures the timing settings at frame start.
module sclk_frame_ctl #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             cpol,
  input  logic [CNT_W-1:0] half_live,
  output logic             active,
  output logic             start,
  output logic [CNT_W-1:0] hp_m1,
  output logic             pol_q
);
  assign start = go && !active;

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      hp_m1  <= '0;
      pol_q  <= 1'b0;
    end else begin
      active <= go;
      if (start) begin
        hp_m1 <= half_live;
        pol_q <= cpol;
      end
    end
  end

  // R7: captured settings do not move while a frame keeps running
  a_r7_shadow_hold: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(hp_m1));
  // R6: captured polarity is frozen during the frame
  a_r6_pol_hold: assert property (@(posedge clk) disable iff (rst)
    (active && $past(active)) |-> $stable(pol_q));
endmodule

// File: rtl/sclk_edge_gen.sv
// Half-period counter, clock toggle and edge pulses, all registered.
module sclk_edge_gen #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             start,
  input  logic             cpol,
  input  logic             pol_q,
  input  logic [CNT_W-1:0] hp_m1,
  input  logic [CNT_W-1:0] load_m1,
  output logic             sclk,
  output logic             lead,
  output logic             trail
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      sclk  <= cpol;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (!go) begin
      cnt   <= '0;
      sclk  <= cpol;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (start) begin
      cnt   <= load_m1;
      sclk  <= cpol;
      lead  <= 1'b0;
      trail <= 1'b0;
    end else if (cnt == '0) begin
      cnt   <= hp_m1;
      sclk  <= ~sclk;
      lead  <= (sclk == pol_q);
      trail <= (sclk != pol_q);
    end else begin
      cnt   <= cnt - CNT_W'(1);
      lead  <= 1'b0;
      trail <= 1'b0;
    end
  end

  // R5: without a frame the clock rests at cpol and no pulse appears
  a_r5_idle: assert property (@(posedge clk) disable iff (rst)
    !go |=> (sclk == $past(cpol)) && !lead && !trail);
  // R4: the leading pulse coincides with the non-idle level
  a_r4_lead_level: assert property (@(posedge clk) disable iff (rst)
    lead |-> (sclk != pol_q));
  // R4: the trailing pulse coincides with the idle level
  a_r4_trail_level: assert property (@(posedge clk) disable iff (rst)
    trail |-> (sclk == pol_q));
  // R4: a pulse marks a real change of sclk
  a_r4_pulse_on_change: assert property (@(posedge clk) disable iff (rst)
    (lead || trail) |-> (sclk != $past(sclk)));
  // R4: two leading pulses never follow back to back
  a_r4_alternate: assert property (@(posedge clk) disable iff (rst)
    lead |=> !lead);
endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import sclk_pkg::*;
#(
  parameter int EXP_W = 4,
  parameter int LIN_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             run,
  input  logic             clk_mode,
  input  logic             cpol,
  input  logic [LIN_W-1:0] div_val,
  output logic             sclk,
  output logic             lead_pulse,
  output logic             trail_pulse
);
  localparam int POW_W = (1 << EXP_W) - 1;
  localparam int CNT_W = (POW_W > LIN_W) ? POW_W : LIN_W;

  logic             go;
  logic             active;
  logic             start;
  logic             pol_q;
  logic [CNT_W-1:0] half_live;
  logic [CNT_W-1:0] hp_m1;

  assign go = en && run;

  sclk_half_calc #(.EXP_W(EXP_W), .LIN_W(LIN_W), .CNT_W(CNT_W)) u_calc (
    .mode    (div_mode_e'(clk_mode)),
    .div     (div_val),
    .half_m1 (half_live)
  );

  sclk_frame_ctl #(.CNT_W(CNT_W)) u_frame (
    .clk       (clk),
    .rst       (rst),
    .go        (go),
    .cpol      (cpol),
    .half_live (half_live),
    .active    (active),
    .start     (start),
    .hp_m1     (hp_m1),
    .pol_q     (pol_q)
  );

  sclk_edge_gen #(.CNT_W(CNT_W)) u_edge (
    .clk     (clk),
    .rst     (rst),
    .go      (go),
    .start   (start),
    .cpol    (cpol),
    .pol_q   (pol_q),
    .hp_m1   (hp_m1),
    .load_m1 (half_live),
    .sclk    (sclk),
    .lead    (lead_pulse),
    .trail   (trail_pulse)
  );

  // R8: sclk changes only while a frame was requested on the prior edge
  a_r8_toggle_in_frame: assert property (@(posedge clk) disable iff (rst)
    (lead_pulse || trail_pulse) |-> $past(go));
  // R4: both pulses never fire together
  a_r4_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(lead_pulse && trail_pulse));
endmodule

// File: tb/test_spi_sclk_gen.sv
module test_spi_sclk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic       run = 1'b0;
  logic       clk_mode = 1'b0;
  logic       cpol = 1'b0;
  logic [7:0] div_val = 8'h00;
  logic       sclk;
  logic       lead_pulse;
  logic       trail_pulse;

  spi_sclk_gen i_spi_sclk_gen (
    .clk(clk), .rst(rst), .en(en), .run(run), .clk_mode(clk_mode),
    .cpol(cpol), .div_val(div_val), .sclk(sclk),
    .lead_pulse(lead_pulse), .trail_pulse(trail_pulse)
  );

  always #4 clk = ~clk;  // 125 MHz

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int    at;
    bit    lead;
    bit    lvl;
    string req;
  } ev_t;
  ev_t q[$];

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int half(bit m, logic [7:0] d);
    return m ? (int'(d) + 1) : (1 << d[3:0]);
  endfunction

  // monitor: pop expected edges as pulses appear
  always @(negedge clk) begin
    ev_t e;
    if (!rst && (lead_pulse || trail_pulse)) begin
      if (q.size() == 0) begin
        chk(1'b0, "R5", "unexpected edge pulse at cycle", cyc, -1);
      end else begin
        e = q.pop_front();
        chk(e.at == cyc, e.req, "edge cycle", cyc, e.at);
        chk(lead_pulse == e.lead && trail_pulse == !e.lead, e.req, "edge kind (1=lead)",
            int'(lead_pulse), int'(e.lead));
        chk(sclk == e.lvl, e.req, "sclk level at edge", int'(sclk), int'(e.lvl));
      end
    end
  end

  // driver: one full frame of n periods, optional mid-frame setting change
  task automatic frame(bit m, logic [7:0] d, bit p, int n, string req, bit chg);
    int h;
    int c;
    h = half(m, d);
    @(posedge clk); #2;
    clk_mode = m; div_val = d; cpol = p; en = 1'b1; run = 1'b1;
    c = cyc;
    for (int i = 1; i <= 2 * n; i++) begin
      ev_t e;
      e.at = c + 1 + i * h;
      e.lead = (i % 2 == 1);
      e.lvl = (i % 2 == 1) ? ~p : p;
      e.req = req;
      q.push_back(e);
    end
    if (chg) begin
      repeat (3) @(posedge clk);
      #2 clk_mode = ~m; div_val = 8'h01;  // R7 mid-frame change
      repeat (2 * n * h + 1 - 3) @(posedge clk);
    end else begin
      repeat (2 * n * h + 1) @(posedge clk);
    end
    #2 run = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(q.size() == 0, req, "edges still pending", q.size(), 0);
    chk(sclk == p, "R5", "idle level after frame", int'(sclk), int'(p));
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (all requirements): actual running expected done");
    finish_run();
  end

  initial begin
    int c;
    ev_t e;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk(sclk == 1'b0 && !lead_pulse && !trail_pulse, "R5", "reset state",
        int'({sclk, lead_pulse, trail_pulse}), 0);
    @(posedge clk); #2 rst = 1'b0;

    frame(1'b0, 8'h00, 1'b0, 3, "R8", 1'b0);   // fastest: toggle every cycle
    frame(1'b0, 8'h03, 1'b0, 2, "R1", 1'b0);   // 2^4 period
    frame(1'b0, 8'hF2, 1'b0, 2, "R1", 1'b0);   // upper bits ignored: 2^3
    frame(1'b0, 8'h09, 1'b0, 1, "R1", 1'b0);   // 2^10 period
    frame(1'b1, 8'h00, 1'b0, 2, "R2", 1'b0);   // linear 2
    frame(1'b1, 8'h04, 1'b0, 3, "R3", 1'b0);   // linear 10
    frame(1'b1, 8'hC8, 1'b0, 1, "R2", 1'b0);   // linear 402
    frame(1'b1, 8'h02, 1'b1, 2, "R6", 1'b0);   // idle-high polarity
    frame(1'b0, 8'h02, 1'b1, 2, "R4", 1'b0);
    frame(1'b1, 8'h05, 1'b0, 2, "R7", 1'b1);   // change mid frame
    frame(1'b0, 8'h01, 1'b0, 2, "R7", 1'b0);   // new settings apply now

    // R5: stop request lands on the cycle of the scheduled trailing edge
    @(posedge clk); #2;
    clk_mode = 1'b1; div_val = 8'h03; cpol = 1'b0; en = 1'b1; run = 1'b1;
    c = cyc;
    e.at = c + 5; e.lead = 1'b1; e.lvl = 1'b1; e.req = "R5";
    q.push_back(e);
    repeat (8) @(posedge clk);
    #2 run = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(sclk == 1'b0, "R5", "sclk idle after stop on edge cycle", int'(sclk), 0);
    chk(q.size() == 0, "R5", "lead before stop missing", q.size(), 0);
    repeat (4) @(negedge clk);
    chk(!trail_pulse && !lead_pulse, "R5", "no pulse after stop",
        int'({lead_pulse, trail_pulse}), 0);

    // R5/R6: run without enable keeps the clock parked at cpol
    @(posedge clk); #2 en = 1'b0; run = 1'b1; cpol = 1'b1;
    repeat (20) @(negedge clk);
    chk(sclk == 1'b1, "R6", "idle high while disabled", int'(sclk), 1);
    @(posedge clk); #2 run = 1'b0; en = 1'b1;
    repeat (3) @(negedge clk);
    chk(q.size() == 0, "R5", "no pulses while disabled", q.size(), 0);

    finish_run();
  end
endmodule